// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores one incoming frame at a time into a ring of receive descriptors that live in host memory. Each descriptor occupies 8 bytes: a control word (word 0) that holds ownership, segment flags and a length, followed by a buffer address (word 1). The block reads the current descriptor through a 32-bit memory master port and checks that the host has handed it over. It then streams frame bytes into that buffer, packing them into 32-bit little-endian words. When the buffer is full and bytes remain, it checks the next descriptor before chaining into it.

Each finished descriptor gets a status word with its byte count. The last one of the chain also carries a last flag, and it carries an overrun flag as well when the next descriptor was not available. The first descriptor's word is written last, with a first flag, so the host never sees a half-built chain. After that write the block pulses a receive event and leaves its current pointer on the descriptor after the chain. Two chip modes differ only in when the ring-end test is made.

The controller is a single state machine. `S_IDLE` waits for a frame or a pointer load and goes to `S_DRAIN` when the channel gate is shut. `S_RD0`/`S_WT0` fetch word 0 and go to `S_DRAIN` when ownership is clear. `S_RD1`/`S_WT1` fetch the buffer address. `S_FILL` accepts bytes, `S_WRD` writes a packed word, and `S_PK`/`S_WTPK` peek the next descriptor. `S_WBS` finishes a descriptor and advances the pointer, looping back to `S_RD1` while the chain continues. `S_WBF` writes the first descriptor, then `S_DRAIN` discards what is left of a truncated or overrun frame.

Top module: `rxring_writer`

## Requirements
- R1: A frame that arrives while `chan_on` is low, `rx_on` is low or `ring_start` is zero is consumed in full with no memory write, no event and no pointer change.
- R2: When word 0 of the current descriptor has bit 31 (ownership) clear, the frame is consumed and discarded with no memory write and no event.
- R3: Each descriptor receives min(word 0 bits [11:0], remaining bytes). Byte k of that share goes to buffer address + k, with byte lane k mod 4 in a 32-bit word. Bytes past the share are left untouched, because the byte enables of a tail word cover only the filled lanes.
- R4: The descriptor where the frame ends gets status bit 29 (last) together with its byte count in bits [11:0]. Bit 31 is cleared in every status written.
- R5: When bytes remain and the next descriptor's bit 31 is set, the current status is the count alone. It is written before the next buffer is used.
- R6: When bytes remain and the next descriptor's bit 31 is clear, the current status is bit 29 plus bit 28 (overrun) plus the count. The rest of the frame is discarded and the pointer moves onto that unowned descriptor.
- R7: Word 0 of the first descriptor is written after all others, with bit 30 (first) ORed into its own status.
- R8: With `chip_mode` = 0 the next descriptor is current+8, replaced by `ring_start` when that sum equals `ring_end`.
- R9: With `chip_mode` = 1 the next descriptor is `ring_start` when the current address equals `ring_end`, and current+8 otherwise.
- R10: Only the first 2048 bytes of a longer frame are stored. The rest of the frame is consumed without effect.
- R11: `rx_event` pulses for one cycle after the first-descriptor write is granted. `in_ready` stays low while any memory request is pending.
- R12: After reset `cur_ptr` is 0. A `ptr_load` pulse in `S_IDLE` copies `ring_start` into `cur_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_mode | input | 1 | Ring-wrap rule select (0: test after step, 1: test before step) |
| chan_on | input | 1 | Channel enabled |
| rx_on | input | 1 | Receive enabled for the channel |
| ring_start | input | AW | Address of the first descriptor |
| ring_end | input | AW | Ring-end address compared by the wrap rule |
| ptr_load | input | 1 | Load `ring_start` into the current pointer |
| cur_ptr | output | AW | Current descriptor address |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of the frame |
| in_ready | output | 1 | Byte accepted this cycle when high with `in_valid` |
| m_req | output | 1 | Memory request valid |
| m_we | output | 1 | Request is a write |
| m_addr | output | AW | Byte address, word aligned |
| m_wdata | output | 32 | Write data |
| m_be | output | 4 | Write byte enables |
| m_gnt | input | 1 | Request accepted |
| m_rvalid | input | 1 | Read data returned |
| m_rdata | input | 32 | Read data |
| rx_event | output | 1 | One-cycle pulse when a frame has been stored |

## Verification
The case that matters most is a frame that ends on the very byte that fills a descriptor. In that cycle the end of the frame and the exhausted buffer arrive together. The end must win: the block writes a last status and makes no peek at the following descriptor. The bench provokes this with a 16-byte frame into 16-byte buffers. It judges the result by the exact first status word, a pointer that advanced by exactly one descriptor, a neighbour descriptor that is left unchanged, and a single event. The 2048-byte truncation case meets the same collision between the byte limit and a full buffer.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LEN_W     = 12;
    localparam int DESC_STEP = 8;
    localparam int BIT_OWN   = 31;
    localparam int BIT_FIRST = 30;
    localparam int BIT_LAST  = 29;
    localparam int BIT_OVR   = 28;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_WT0, S_RD1, S_WT1, S_FILL, S_WRD,
        S_PK, S_WTPK, S_WBS, S_WBF, S_DRAIN
    } rxr_state_e;

    function automatic logic [31:0] stat_word(input logic ls, input logic ovr,
                                              input logic [LEN_W-1:0] n);
        logic [31:0] w;
        w = 32'(n);
        w[BIT_LAST] = ls;
        w[BIT_OVR]  = ovr;
        return w;
    endfunction
endpackage

// File: rtl/rxr_next_ptr.sv
module rxr_next_ptr
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          mode,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] stop,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] stepped;
    assign stepped = cur + AW'(DESC_STEP);

    always_comb begin
        if (mode) nxt = (cur == stop) ? start : stepped;
        else      nxt = (stepped == stop) ? start : stepped;
    end
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [7:0]                 din,
    output logic [8*LANES-1:0]         word,
    output logic [LANES-1:0]           be,
    output logic [$clog2(LANES):0]     fill
);
    localparam int FW = $clog2(LANES) + 1;

    logic [7:0]   lane_q [LANES];
    logic [LANES-1:0] be_q;
    logic [FW-1:0] fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            be_q   <= '0;
            for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
        end else if (clr) begin
            fill_q <= '0;
            be_q   <= '0;
        end else if (push) begin
            for (int i = 0; i < LANES; i++) begin
                if (fill_q == FW'(i)) begin
                    lane_q[i] <= din;
                    be_q[i]   <= 1'b1;
                end
            end
            fill_q <= fill_q + FW'(1);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word[8*g +: 8] = lane_q[g];
    end
    assign be   = be_q;
    assign fill = fill_q;
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
    import rxr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_mode,
    input  logic          chan_on,
    input  logic          rx_on,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_end,
    input  logic          ptr_load,
    output logic [AW-1:0] cur_ptr,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [31:0]   m_wdata,
    output logic [3:0]    m_be,
    input  logic          m_gnt,
    input  logic          m_rvalid,
    input  logic [31:0]   m_rdata,
    output logic          rx_event
);
    localparam int TOT_W = $clog2(MAX_FRAME) + 1;
    localparam int LANES = 4;
    localparam int FW    = $clog2(LANES) + 1;

    rxr_state_e state_q, state_d;

    logic [AW-1:0]    cur_q, dsc_q, first_q, buf_q, nxt;
    logic [LEN_W-1:0] blen_q, pk_len_q, cnt_q, off_q;
    logic [TOT_W-1:0] tot_q;
    logic [31:0]      st_q, first_st_q;
    logic             got_last_q, is_first_q, chain_end_q, evt_q;

    logic [31:0]   pk_word;
    logic [3:0]    pk_be;
    logic [FW-1:0] pk_fill;
    logic          gate_ok, ended, dsc_full, flush, room, take, pk_clr;

    rxr_next_ptr #(.AW(AW)) u_next (
        .mode(chip_mode), .cur(dsc_q), .start(ring_start), .stop(ring_end), .nxt(nxt)
    );

    rxr_packer #(.LANES(LANES)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .push(take), .din(in_data),
        .word(pk_word), .be(pk_be), .fill(pk_fill)
    );

    assign gate_ok  = chan_on && rx_on && (ring_start != '0);
    assign ended    = got_last_q || (tot_q == TOT_W'(MAX_FRAME));
    assign dsc_full = (cnt_q == blen_q);
    assign flush    = (pk_fill == FW'(LANES)) || ((pk_fill != '0) && (ended || dsc_full));
    assign room     = (state_q == S_FILL) && !flush && !ended && !dsc_full;
    assign take     = room && in_valid;
    assign pk_clr   = (state_q == S_WRD) && m_gnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (!ptr_load && in_valid) state_d = gate_ok ? S_RD0 : S_DRAIN;
            S_RD0:   if (m_gnt) state_d = S_WT0;
            S_WT0:   if (m_rvalid) state_d = m_rdata[BIT_OWN] ? S_RD1 : S_DRAIN;
            S_RD1:   if (m_gnt) state_d = S_WT1;
            S_WT1:   if (m_rvalid) state_d = S_FILL;
            S_FILL: begin
                if (flush)         state_d = S_WRD;
                else if (ended)    state_d = S_WBS;
                else if (dsc_full) state_d = S_PK;
            end
            S_WRD:   if (m_gnt) state_d = S_FILL;
            S_PK:    if (m_gnt) state_d = S_WTPK;
            S_WTPK:  if (m_rvalid) state_d = S_WBS;
            S_WBS:   if (is_first_q || m_gnt) state_d = chain_end_q ? S_WBF : S_RD1;
            S_WBF:   if (m_gnt) state_d = got_last_q ? S_IDLE : S_DRAIN;
            S_DRAIN: if (in_valid && in_last) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        m_req    = 1'b0;
        m_we     = 1'b0;
        m_addr   = dsc_q;
        m_wdata  = st_q;
        m_be     = 4'hF;
        in_ready = room || (state_q == S_DRAIN);
        unique case (state_q)
            S_RD0:   m_req = 1'b1;
            S_RD1:   begin m_req = 1'b1; m_addr = dsc_q + AW'(4); end
            S_PK:    begin m_req = 1'b1; m_addr = nxt; end
            S_WRD:   begin m_req = 1'b1; m_we = 1'b1; m_addr = buf_q + AW'(off_q);
                           m_wdata = pk_word; m_be = pk_be; end
            S_WBS:   begin m_req = !is_first_q; m_we = 1'b1; end
            S_WBF:   begin m_req = 1'b1; m_we = 1'b1; m_addr = first_q;
                           m_wdata = first_st_q | (32'd1 << BIT_FIRST); end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0; dsc_q <= '0; first_q <= '0; buf_q <= '0;
            blen_q <= '0; pk_len_q <= '0; cnt_q <= '0; off_q <= '0; tot_q <= '0;
            st_q <= '0; first_st_q <= '0;
            got_last_q <= 1'b0; is_first_q <= 1'b0; chain_end_q <= 1'b0; evt_q <= 1'b0;
        end else begin
            evt_q <= (state_q == S_WBF) && m_gnt;
            case (state_q)
                S_IDLE: begin
                    if (ptr_load) cur_q <= ring_start;
                    else if (in_valid && gate_ok) begin
                        dsc_q <= cur_q; first_q <= cur_q; is_first_q <= 1'b1;
                        tot_q <= '0; got_last_q <= 1'b0;
                    end
                end
                S_WT0: if (m_rvalid) blen_q <= m_rdata[LEN_W-1:0];
                S_WT1: if (m_rvalid) begin buf_q <= m_rdata; cnt_q <= '0; off_q <= '0; end
                S_FILL: begin
                    if (take) begin
                        cnt_q <= cnt_q + LEN_W'(1);
                        tot_q <= tot_q + TOT_W'(1);
                        got_last_q <= in_last;
                    end else if (!flush && ended) begin
                        st_q <= stat_word(1'b1, 1'b0, cnt_q);
                        chain_end_q <= 1'b1;
                    end
                end
                S_WRD: if (m_gnt) off_q <= off_q + LEN_W'(LANES);
                S_WTPK: if (m_rvalid) begin
                    pk_len_q    <= m_rdata[LEN_W-1:0];
                    st_q        <= stat_word(!m_rdata[BIT_OWN], !m_rdata[BIT_OWN], cnt_q);
                    chain_end_q <= !m_rdata[BIT_OWN];
                end
                S_WBS: if (is_first_q || m_gnt) begin
                    cur_q <= nxt;
                    if (is_first_q) first_st_q <= st_q;
                    if (!chain_end_q) begin
                        dsc_q <= nxt; blen_q <= pk_len_q; is_first_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cur_ptr  = cur_q;
    assign rx_event = evt_q;

    // Checks
    assert_ready_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !m_req);
    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_we)));
    assert_event_after_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> $past(m_req && m_gnt && m_we && m_wdata[BIT_FIRST]));
    assert_no_overrun_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tot_q <= TOT_W'(MAX_FRAME));
    assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q != $past(cur_q)) && !$past(ptr_load)) |->
        ((cur_q == ring_start) || (cur_q == $past(cur_q) + AW'(DESC_STEP))));
    assert_status_not_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we && (m_addr == first_q) && (state_q == S_WBF)) |-> !m_wdata[BIT_OWN]);
endmodule

// File: tb/rxring_writer_test.sv
module rxring_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_mode = 1'b0, chan_on = 1'b1, rx_on = 1'b1, ptr_load = 1'b0;
    logic [31:0] ring_start = 32'h100, ring_end = 32'h120, cur_ptr;
    logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        m_req, m_we, m_gnt, m_rvalid = 1'b0, rx_event;
    logic [31:0] m_addr, m_wdata, m_rdata = 32'h0;
    logic [3:0]  m_be;

    int checks = 0, errors = 0;
    int wr_cnt = 0, ev_cnt = 0;
    logic [1:0] gtick = 2'd0;
    logic [31:0] mem [0:1023];

    always #5 clk = ~clk;

    rxring_writer uut (
        .clk(clk), .rst_n(rst_n), .chip_mode(chip_mode), .chan_on(chan_on), .rx_on(rx_on),
        .ring_start(ring_start), .ring_end(ring_end), .ptr_load(ptr_load), .cur_ptr(cur_ptr),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
        .m_gnt(m_gnt), .m_rvalid(m_rvalid), .m_rdata(m_rdata), .rx_event(rx_event)
    );

    assign m_gnt = m_req && (gtick != 2'd3);

    always @(posedge clk) begin
        gtick <= gtick + 2'd1;
        m_rvalid <= 1'b0;
        if (m_req && m_gnt) begin
            if (m_we) begin
                for (int b = 0; b < 4; b++)
                    if (m_be[b]) mem[m_addr[11:2]][8*b +: 8] = m_wdata[8*b +: 8];
                wr_cnt <= wr_cnt + 1;
            end else begin
                m_rvalid <= 1'b1;
                m_rdata  <= mem[m_addr[11:2]];
            end
        end
        if (rx_event) ev_cnt <= ev_cnt + 1;
    end

    typedef struct packed {
        logic        mode;
        logic [11:0] flen;
        logic [11:0] blen;
        logic [3:0]  own;
        logic [31:0] e0, e1, e2, e3;
        logic [31:0] ecur;
        logic [1:0]  eev;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 12'd10, 12'd16, 4'b1111, 32'h6000000A, 32'h80000010, 32'h80000010, 32'h80000010, 32'h108, 2'd1},
        '{1'b1, 12'd20, 12'd8,  4'b1111, 32'h40000008, 32'h00000008, 32'h20000004, 32'h80000008, 32'h118, 2'd1},
        '{1'b0, 12'd20, 12'd8,  4'b0011, 32'h40000008, 32'h30000008, 32'h00000008, 32'h00000008, 32'h110, 2'd1},
        '{1'b1, 12'd5,  12'd16, 4'b1110, 32'h00000010, 32'h80000010, 32'h80000010, 32'h80000010, 32'h100, 2'd0},
        '{1'b0, 12'd16, 12'd16, 4'b1111, 32'h60000010, 32'h80000010, 32'h80000010, 32'h80000010, 32'h108, 2'd1},
        '{1'b1, 12'd7,  12'd3,  4'b1111, 32'h40000003, 32'h00000003, 32'h20000001, 32'h80000003, 32'h118, 2'd1}
    };

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 7) + (seed * 13) + 1);
    endfunction

    function automatic logic [7:0] mbyte(input int a);
        return mem[a >> 2][8 * (a % 4) +: 8];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic init_ring(input int blen, input logic [3:0] own);
        for (int w = 256; w < 512; w++) mem[w] = 32'hEEEEEEEE;
        for (int s = 0; s < 4; s++) begin
            mem[64 + 2*s]     = {own[s], 19'd0, 12'(blen)};
            mem[64 + 2*s + 1] = 32'h400 + 32'(s * 256);
        end
    endtask

    task automatic load_ptr();
        @(negedge clk); ptr_load = 1'b1;
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = pat(i, seed); in_last = (i == n - 1);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic verify_data(input int flen, input int blen, input logic [3:0] own,
                               input int seed, input string tag);
        int rem, s, bad, take, idx, lastbuf;
        bit stop;
        rem = (flen > 2048) ? 2048 : flen;
        s = 0; bad = 0; idx = 0; lastbuf = 32'h400; stop = !own[0];
        while (!stop && rem > 0) begin
            take = (rem < blen) ? rem : blen;
            for (int k = 0; k < take; k++)
                if (mbyte(32'h400 + s*256 + k) !== pat(idx + k, seed)) bad++;
            idx += take; rem -= take;
            lastbuf = 32'h400 + s*256 + take;
            if (rem > 0) begin
                s++;
                if (s > 3 || !own[s]) stop = 1'b1;
            end
        end
        if (mbyte(lastbuf) !== 8'hEE) bad++;
        check(bad == 0, tag, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int ev0, wr0;
        logic [31:0] seq0 [4];
        logic [31:0] seq1 [4];
        seq0 = '{32'h108, 32'h110, 32'h100, 32'h108};
        seq1 = '{32'h108, 32'h110, 32'h118, 32'h100};
        for (int w = 0; w < 1024; w++) mem[w] = 32'h0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cur_ptr == 32'h0, "R12 reset pointer", cur_ptr, 32'h0);
        check(m_req == 1'b0, "R11 reset request", 32'(m_req), 32'h0);
        check(rx_event == 1'b0, "R11 reset event", 32'(rx_event), 32'h0);

        load_ptr();
        check(cur_ptr == 32'h100, "R12 pointer load", cur_ptr, 32'h100);

        // Table of frames, each from slot 0
        for (int r = 0; r < NROWS; r++) begin
            chip_mode = ROWS[r].mode;
            ring_end  = ROWS[r].mode ? 32'h118 : 32'h120;
            init_ring(int'(ROWS[r].blen), ROWS[r].own);
            load_ptr();
            ev0 = ev_cnt;
            send_frame(int'(ROWS[r].flen), r);
            settle();
            check(mem[64] == ROWS[r].e0, "R7 R4 R2 first slot", mem[64], ROWS[r].e0);
            check(mem[66] == ROWS[r].e1, "R5 R6 slot1", mem[66], ROWS[r].e1);
            check(mem[68] == ROWS[r].e2, "R4 R5 slot2", mem[68], ROWS[r].e2);
            check(mem[70] == ROWS[r].e3, "R6 slot3", mem[70], ROWS[r].e3);
            check(cur_ptr == ROWS[r].ecur, ROWS[r].mode ? "R9 pointer" : "R8 pointer",
                  cur_ptr, ROWS[r].ecur);
            check(ev_cnt - ev0 == int'(ROWS[r].eev), "R11 event count",
                  32'(ev_cnt - ev0), 32'(ROWS[r].eev));
            verify_data(int'(ROWS[r].flen), int'(ROWS[r].blen), ROWS[r].own, r, "R3 buffer data");
        end

        // Gate closed: channel off, receive off, zero start
        chip_mode = 1'b0; ring_end = 32'h120;
        init_ring(16, 4'b1111);
        load_ptr();
        for (int v = 0; v < 3; v++) begin
            chan_on = (v != 0); rx_on = (v != 1); ring_start = (v == 2) ? 32'h0 : 32'h100;
            ev0 = ev_cnt; wr0 = wr_cnt;
            send_frame(6, 9);
            settle();
            check(wr_cnt == wr0, "R1 no write when gated", 32'(wr_cnt - wr0), 32'h0);
            check(ev_cnt == ev0, "R1 no event when gated", 32'(ev_cnt - ev0), 32'h0);
            check(cur_ptr == 32'h100, "R1 pointer kept", cur_ptr, 32'h100);
        end
        chan_on = 1'b1; rx_on = 1'b1; ring_start = 32'h100;

        // Wrap rules with the same ring end in both modes
        ring_end = 32'h118;
        for (int m = 0; m < 2; m++) begin
            chip_mode = m[0];
            load_ptr();
            for (int f = 0; f < 4; f++) begin
                init_ring(16, 4'b1111);
                send_frame(1, f);
                settle();
                if (m == 0) check(cur_ptr == seq0[f], "R8 wrap sequence", cur_ptr, seq0[f]);
                else        check(cur_ptr == seq1[f], "R9 wrap sequence", cur_ptr, seq1[f]);
            end
        end

        // Truncation at 2048 bytes
        chip_mode = 1'b0; ring_end = 32'h120;
        init_ring(2048, 4'b1111);
        mem[65] = 32'h800;
        load_ptr();
        ev0 = ev_cnt;
        send_frame(2100, 3);
        settle();
        check(mem[64] == 32'h60000800, "R10 truncated status", mem[64], 32'h60000800);
        check(mem[66] == 32'h80000800, "R10 no chain after limit", mem[66], 32'h80000800);
        check(mbyte(32'h800 + 2047) == pat(2047, 3), "R10 last stored byte",
              32'(mbyte(32'h800 + 2047)), 32'(pat(2047, 3)));
        check(ev_cnt - ev0 == 1, "R11 truncated event", 32'(ev_cnt - ev0), 32'd1);
        check(cur_ptr == 32'h108, "R8 truncated pointer", cur_ptr, 32'h108);

        finish_run();
    end
endmodule